// File: doc/BRIEF.md
# Run-Time Processor Invariant Monitor

This block is a small synthesizable monitor placed next to a 32-bit integer unit. It watches the processor's status bits, the instruction in the decode stage and the exception lines it raises. On every clock cycle, in parallel with normal execution, it evaluates four security invariants. A broken invariant points to logic that has been tampered with, because correct hardware never breaks one.

Each invariant owns a two-state flag machine. In state ARMED the flag reads 0. The transition TRIP moves it to TRIPPED on the clock edge that ends a cycle in which the invariant was broken. In TRIPPED the transition HOLD keeps it there whatever the processor does next. The only way back to ARMED is the transition CLEAR, which happens when the monitor's own active-low reset is asserted. The processor reset cannot clear a flag, because the processor reset is one of the signals being watched. The alarm output is the OR of all four flags.

Top module: `inv_monitor`

## Requirements
- R1: All four invariants are evaluated in every cycle and independently of each other. Violations of several invariants in the same cycle set all of the matching flags together.
- R2: If `cpu_rst` is 1 while `mode_priv` is 0, flag bit 0 is set.
- R3: If `trap_en` is 1 while `mode_priv` is 0, flag bit 1 is set.
- R4: Flag bit 2 is set when all of these hold in a valid decode cycle: the instruction has op field bits[31:30] = 2, its op3 field bits[24:19] = 6'b110001 (the state-register write), `mode_priv` is 0, and `exc_priv` is 0. An op value other than 2 never triggers this check.
- R5: Flag bit 3 is set when a valid decode cycle has op2 field bits[24:22] equal to 3'b001 or 3'b101 and `exc_illegal` is 0.
- R6: When `dec_valid` is 0, the instruction and the two exception inputs have no effect on flag bits 2 and 3.
- R7: Flags are sticky. Once set, a flag stays set through any later processor activity, including `cpu_rst`, until `chk_rst_n` is asserted low. Asserting `chk_rst_n` clears every flag.
- R8: A flag and `alarm` rise at the clock edge that ends the offending cycle, so they are visible one cycle later. `alarm` is 1 exactly when any flag is 1.
- R9: While `chk_rst_n` is asserted and right after it is released, all flags and `alarm` are 0.
- R10: A cycle that meets every invariant sets no flag. Examples: a supervisor-mode state-register write with no exception, a user-mode state-register write that raises `exc_priv`, and a legal op2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the processor |
| chk_rst_n | input | 1 | Active-low asynchronous reset of the monitor only |
| cpu_rst | input | 1 | Processor reset (watched, not obeyed) |
| mode_priv | input | 1 | Supervisor-mode status bit |
| trap_en | input | 1 | Trap-enable status bit |
| dec_valid | input | 1 | Decode-stage instruction valid strobe |
| dec_instr | input | 32 | Instruction word in the decode stage |
| exc_priv | input | 1 | Privileged-instruction exception raised by the processor |
| exc_illegal | input | 1 | Illegal-instruction exception raised by the processor |
| viol_flags | output | 4 | Sticky violation flags, one bit per invariant (R2..R5 order) |
| alarm | output | 1 | OR of all violation flags |

## Verification
The bench covers the following corner cases:
- An instruction that carries the state-register-write op3 but has op = 3. A decoder that ignored the op field would flag it wrongly.
- A user-mode write that correctly raises `exc_priv`. A monitor with inverted exception sense would alarm on it.
- Violating patterns presented with `dec_valid` low. These catch a monitor that does not gate its instruction checks on the strobe.
- Reasserting the processor reset after a flag has tripped. A design that cleared on the processor reset would lose that flag.
- A cycle that breaks two invariants at once. An implementation with a priority encoder would keep only one of them.

// File: rtl/invmon_pkg.sv
package invmon_pkg;

    localparam int NUM_PROPS = 4;

    localparam int P_RESET_PRIV = 0;
    localparam int P_TRAP_PRIV  = 1;
    localparam int P_STATE_WR   = 2;
    localparam int P_OPCODE_ILL = 3;

    typedef enum logic {
        FLG_ARMED   = 1'b0,
        FLG_TRIPPED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/inv_field_decode.sv
module inv_field_decode #(
    parameter int          XLEN    = 32,
    parameter int          OP_LSB  = 30,
    parameter int          OP2_LSB = 22,
    parameter int          OP3_LSB = 19,
    parameter logic [1:0]  FMT_OP  = 2'd2,
    parameter logic [5:0]  WSR_OP3 = 6'b110001,
    parameter logic [2:0]  ILL_A   = 3'b001,
    parameter logic [2:0]  ILL_B   = 3'b101
) (
    input  logic [XLEN-1:0] instr,
    output logic            is_state_wr,
    output logic            is_ill_op2
);
    localparam int OP_W  = 2;
    localparam int OP2_W = 3;
    localparam int OP3_W = 6;

    logic [OP_W-1:0]  f_op;
    logic [OP2_W-1:0] f_op2;
    logic [OP3_W-1:0] f_op3;
    logic             unused_instr_bits;

    assign f_op  = instr[OP_LSB  +: OP_W];
    assign f_op2 = instr[OP2_LSB +: OP2_W];
    assign f_op3 = instr[OP3_LSB +: OP3_W];
    assign unused_instr_bits = ^instr;

    always_comb begin
        is_state_wr = (f_op == FMT_OP) && (f_op3 == WSR_OP3);
        is_ill_op2  = (f_op2 == ILL_A) || (f_op2 == ILL_B);
    end
endmodule

// File: rtl/inv_rules.sv
module inv_rules
    import invmon_pkg::*;
(
    input  logic                 cpu_rst,
    input  logic                 mode_priv,
    input  logic                 trap_en,
    input  logic                 dec_valid,
    input  logic                 is_state_wr,
    input  logic                 is_ill_op2,
    input  logic                 exc_priv,
    input  logic                 exc_illegal,
    output logic [NUM_PROPS-1:0] hit
);
    always_comb begin
        hit               = '0;
        hit[P_RESET_PRIV] = cpu_rst && !mode_priv;
        hit[P_TRAP_PRIV]  = trap_en && !mode_priv;
        hit[P_STATE_WR]   = dec_valid && is_state_wr && !mode_priv && !exc_priv;
        hit[P_OPCODE_ILL] = dec_valid && is_ill_op2 && !exc_illegal;
    end
endmodule

// File: rtl/inv_flag_fsm.sv
module inv_flag_fsm
    import invmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_ARMED:   if (hit) state_d = FLG_TRIPPED;
            FLG_TRIPPED: state_d = FLG_TRIPPED;
            default:     state_d = FLG_ARMED;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_TRIPPED);
    end

    // R8: a violation is visible on the flag one edge later
    a_r8_trip_latency: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
endmodule

// File: rtl/inv_monitor.sv
module inv_monitor
    import invmon_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          OP_LSB  = 30,
    parameter int          OP2_LSB = 22,
    parameter int          OP3_LSB = 19,
    parameter logic [1:0]  FMT_OP  = 2'd2,
    parameter logic [5:0]  WSR_OP3 = 6'b110001,
    parameter logic [2:0]  ILL_A   = 3'b001,
    parameter logic [2:0]  ILL_B   = 3'b101
) (
    input  logic                 clk,
    input  logic                 chk_rst_n,
    input  logic                 cpu_rst,
    input  logic                 mode_priv,
    input  logic                 trap_en,
    input  logic                 dec_valid,
    input  logic [XLEN-1:0]      dec_instr,
    input  logic                 exc_priv,
    input  logic                 exc_illegal,
    output logic [NUM_PROPS-1:0] viol_flags,
    output logic                 alarm
);
    logic                 is_state_wr;
    logic                 is_ill_op2;
    logic [NUM_PROPS-1:0] hit;

    inv_field_decode #(
        .XLEN(XLEN), .OP_LSB(OP_LSB), .OP2_LSB(OP2_LSB), .OP3_LSB(OP3_LSB),
        .FMT_OP(FMT_OP), .WSR_OP3(WSR_OP3), .ILL_A(ILL_A), .ILL_B(ILL_B)
    ) u_decode (
        .instr       (dec_instr),
        .is_state_wr (is_state_wr),
        .is_ill_op2  (is_ill_op2)
    );

    inv_rules u_rules (
        .cpu_rst     (cpu_rst),
        .mode_priv   (mode_priv),
        .trap_en     (trap_en),
        .dec_valid   (dec_valid),
        .is_state_wr (is_state_wr),
        .is_ill_op2  (is_ill_op2),
        .exc_priv    (exc_priv),
        .exc_illegal (exc_illegal),
        .hit         (hit)
    );

    for (genvar gi = 0; gi < NUM_PROPS; gi++) begin : g_flag
        inv_flag_fsm u_flag (
            .clk   (clk),
            .rst_n (chk_rst_n),
            .hit   (hit[gi]),
            .flag  (viol_flags[gi])
        );
    end

    always_comb begin
        alarm = |viol_flags;
    end

    // R2
    a_r2_reset_needs_priv: assert property (@(posedge clk) disable iff (!chk_rst_n)
        (cpu_rst && !mode_priv) |=> viol_flags[P_RESET_PRIV]);
    // R3
    a_r3_trap_needs_priv: assert property (@(posedge clk) disable iff (!chk_rst_n)
        (trap_en && !mode_priv) |=> viol_flags[P_TRAP_PRIV]);
    // R4
    a_r4_state_wr_priv: assert property (@(posedge clk) disable iff (!chk_rst_n)
        (dec_valid && dec_instr[OP_LSB +: 2] == FMT_OP
         && dec_instr[OP3_LSB +: 6] == WSR_OP3 && !mode_priv && !exc_priv)
        |=> viol_flags[P_STATE_WR]);
    // R5
    a_r5_illegal_op2: assert property (@(posedge clk) disable iff (!chk_rst_n)
        (dec_valid && (dec_instr[OP2_LSB +: 3] == ILL_A
                       || dec_instr[OP2_LSB +: 3] == ILL_B) && !exc_illegal)
        |=> viol_flags[P_OPCODE_ILL]);
    // R7: no flag ever drops while the monitor reset is released
    a_r7_sticky: assert property (@(posedge clk) disable iff (!chk_rst_n)
        1'b1 |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));
    // R8: alarm only rises after some invariant was broken
    a_r8_alarm_cause: assert property (@(posedge clk) disable iff (!chk_rst_n)
        $rose(alarm) |-> $past(|hit));
    // R6: with no valid decode, the instruction flags cannot newly rise
    a_r6_gate_valid: assert property (@(posedge clk) disable iff (!chk_rst_n)
        !dec_valid |=> (viol_flags[P_STATE_WR] == $past(viol_flags[P_STATE_WR])
                        && viol_flags[P_OPCODE_ILL] == $past(viol_flags[P_OPCODE_ILL])));
endmodule

// File: tb/inv_monitor_test.sv
`timescale 1ns/1ps
module inv_monitor_test;
    logic        clk = 1'b0;
    logic        chk_rst_n = 1'b0;
    logic        cpu_rst = 1'b1;
    logic        mode_priv = 1'b1;
    logic        trap_en = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_instr = '0;
    logic        exc_priv = 1'b0;
    logic        exc_illegal = 1'b0;
    logic [3:0]  viol_flags;
    logic        alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] flags;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    inv_monitor uut (
        .clk(clk), .chk_rst_n(chk_rst_n), .cpu_rst(cpu_rst), .mode_priv(mode_priv),
        .trap_en(trap_en), .dec_valid(dec_valid), .dec_instr(dec_instr),
        .exc_priv(exc_priv), .exc_illegal(exc_illegal),
        .viol_flags(viol_flags), .alarm(alarm)
    );

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [5:0] op3);
        return {op, 5'b00000, op3, 19'd0};
    endfunction

    task automatic compare(input logic [3:0] exp, input string tag);
        checks++;
        if (viol_flags !== exp || alarm !== (|exp)) begin
            errors++;
            $display("FAIL %s flags=%b alarm=%b expected flags=%b alarm=%b",
                     tag, viol_flags, alarm, exp, |exp);
        end
    endtask

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.flags, e.tag);
        end
    end

    task automatic idle_inputs();
        cpu_rst = 0; mode_priv = 1; trap_en = 0; dec_valid = 0;
        dec_instr = '0; exc_priv = 0; exc_illegal = 0;
    endtask

    task automatic step(input logic r, input logic s, input logic et, input logic v,
                        input logic [31:0] ins, input logic ep, input logic ei,
                        input logic [3:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_rst = r; mode_priv = s; trap_en = et; dec_valid = v;
        dec_instr = ins; exc_priv = ep; exc_illegal = ei;
        @(posedge clk);
        e.flags = exp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk_clear();
        exp_t e;
        @(negedge clk);
        idle_inputs();
        chk_rst_n = 0;
        @(posedge clk);
        e.flags = 4'b0000; e.tag = "R7 checker reset clears";
        sb.push_back(e);
        @(negedge clk);
        chk_rst_n = 1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(4'b0000, "R9 during checker reset");
        chk_rst_n = 1;
        // R9 / R10: processor reset with supervisor bit set is legal
        step(1, 1, 0, 0, '0, 0, 0, 4'b0000, "R9 R10 legal reset");
        // R2 and R8
        step(1, 0, 0, 0, '0, 0, 0, 4'b0001, "R2 R8 reset without supervisor");
        // R7: processor reset and legal traffic do not clear the flag
        step(1, 1, 0, 0, '0, 0, 0, 4'b0001, "R7 sticky over cpu reset");
        step(0, 1, 0, 0, '0, 0, 0, 4'b0001, "R7 sticky idle");
        chk_clear();
        // R3
        step(0, 1, 1, 0, '0, 0, 0, 4'b0000, "R10 trap enable in supervisor");
        step(0, 0, 1, 0, '0, 0, 0, 4'b0010, "R3 trap enable in user mode");
        chk_clear();
        // R4 family
        step(0, 0, 0, 1, mk(2'd2, 6'b110001), 1, 0, 4'b0000, "R10 user write trapped");
        step(0, 1, 0, 1, mk(2'd2, 6'b110001), 0, 0, 4'b0000, "R10 supervisor write");
        step(0, 0, 0, 1, mk(2'd3, 6'b110001), 0, 0, 4'b0000, "R4 op not 2 ignored");
        step(0, 0, 0, 0, mk(2'd2, 6'b110001), 0, 0, 4'b0000, "R6 invalid write ignored");
        step(0, 0, 0, 1, mk(2'd2, 6'b110001), 0, 0, 4'b0100, "R4 user write untrapped");
        chk_clear();
        // R5 family
        step(0, 1, 0, 1, mk(2'd0, {3'b011, 3'b000}), 0, 0, 4'b0000, "R10 legal op2");
        step(0, 1, 0, 1, mk(2'd0, {3'b001, 3'b000}), 0, 1, 4'b0000, "R10 illegal op2 trapped");
        step(0, 1, 0, 0, mk(2'd0, {3'b101, 3'b000}), 0, 0, 4'b0000, "R6 invalid op2 ignored");
        step(0, 1, 0, 1, mk(2'd0, {3'b101, 3'b000}), 0, 0, 4'b1000, "R5 op2 101 untrapped");
        chk_clear();
        step(0, 1, 0, 1, mk(2'd0, {3'b001, 3'b000}), 0, 0, 4'b1000, "R5 op2 001 untrapped");
        chk_clear();
        // R1: two invariants broken in one cycle
        step(1, 0, 1, 0, '0, 0, 0, 4'b0011, "R1 simultaneous violations");
        step(0, 0, 0, 1, mk(2'd2, 6'b110001), 0, 0, 4'b0111, "R1 third flag joins");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule